// File: doc/BRIEF.md
# Priority-Sorted Interrupt Pending Queue

This block holds the interrupt requests that are waiting to be serviced, kept in ascending order of kind code, so the most urgent request is always in the highest occupied slot (the tail). Every stored entry records the kind code, its class, the program counter that was current when the request arrived, and the issue slot of the instruction that raised it. A service unit reads the tail and pops it. An exception unit can delete every entry whose class falls in an inclusive band in a single operation.

Requests enter on a valid/ready stream. The block takes an insert when `ins_valid` and `ins_ready` are both high on a rising edge. `ins_ready` goes low when the queue is full, and also in any cycle where a clear or a pop has been requested. The source must then hold its request. The tail is a valid/ready stream too: `tail_valid` means the queue is not empty, and a pop takes place when `tail_valid` and `tail_ready` are both high. An accepted external request is discarded when the trap-enable input is low, or when its level is below the current processor level. Level 15 is exempt from the level test. An accepted external request whose kind matches the entry at its insertion point is merged with that entry.

Kind codes are 6 bits. Kind k in 0..14 is external level k+1, 15 is the software trap, 16..61 are program exceptions, 62 is break and 63 is reset. A larger kind code is more urgent. Class codes are 3 bits: 0 external, 1 software, 2 program, 3 break, 4 reset.

Top module: `irq_pend_queue`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `tail_valid` is 0, `overflow` is 0 and `ins_ready` is 1.
- R2: Stored entries are in ascending kind order, and the tail shows the entry with the largest kind. A new entry goes just below the first stored entry whose kind is greater than or equal to its own, and all entries above that point move up one place. As a result, among equal non-external kinds the oldest entry is nearest the tail.
- R3: An accepted request of class 0 (external) whose kind equals the kind at its insertion point adds no entry. In that cycle `ins_dup` is high and `count` does not change.
- R4: An accepted request of class 0 is discarded, with `ins_masked` high and `count` unchanged, when `ext_enable` is 0. It is also discarded when its level (kind+1) is below `cur_level`, except for kind 14 (level 15), which the level test never masks. A level equal to `cur_level` is kept.
- R5: Each entry keeps the `ins_pc` and `ins_slot` values present when it was accepted, and shows them on `tail_pc` and `tail_slot` when it reaches the tail.
- R6: A clear removes every stored entry whose class c satisfies `clr_lo` <= c <= `clr_hi`. The remaining entries keep their relative order and close up the gaps, and `count` falls by the number of entries removed. A band with `clr_lo` > `clr_hi` removes nothing.
- R7: A pop removes the tail entry and decreases `count` by one. The entry below it becomes the new tail.
- R8: When `count` equals DEPTH, `ins_ready` is 0. An insert presented while the queue is full, with no clear or pop in that cycle, is ignored and sets `overflow`. `overflow` then stays set until reset.
- R9: Only one operation takes effect per cycle. A clear wins over a pop, and a pop wins over an insert. `ins_ready` is 0 in any cycle that has a clear or a pop requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert can be accepted this cycle |
| ins_kind | input | 6 | Kind code of the request |
| ins_class | input | 3 | Class code of the request |
| ins_pc | input | PC_W | Program counter captured with the request |
| ins_slot | input | SLOT_W | Issue slot captured with the request |
| ins_dup | output | 1 | Accepted external request merged with an existing entry |
| ins_masked | output | 1 | Accepted external request discarded by the gating test |
| ext_enable | input | 1 | Trap enable for external requests |
| cur_level | input | 4 | Current processor interrupt level |
| tail_valid | output | 1 | Queue not empty; tail fields are meaningful |
| tail_ready | input | 1 | Pop the tail entry |
| tail_kind | output | 6 | Kind of the tail entry |
| tail_class | output | 3 | Class of the tail entry |
| tail_pc | output | PC_W | Program counter of the tail entry |
| tail_slot | output | SLOT_W | Issue slot of the tail entry |
| clr_req | input | 1 | Remove all entries in the class band |
| clr_lo | input | 3 | Lowest class in the band |
| clr_hi | input | 3 | Highest class in the band |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow | output | 1 | Sticky: an insert was presented while full |

## Verification
Directed inserts that arrive out of order, including equal program kinds with different PCs, check that sorting holds and that the oldest equal entry sits nearest the tail. This would expose an insertion point placed after equal entries rather than before them. External requests at levels just below, equal to and above the processor level, together with level 15 and a cleared enable bit, separate the two masking conditions and the level-15 exemption. Band clears with empty, single-class and full-range bands, and same-cycle clear/pop/insert combinations, check compaction and precedence. A long seeded random mix of all four operations is then compared cycle by cycle with a behavioural queue model.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  localparam int KIND_W  = 6;
  localparam int CLASS_W = 3;
  localparam int LEVEL_W = 4;

  // Class codes (a band clear selects on these numerically)
  localparam logic [CLASS_W-1:0] CLS_EXT  = 3'd0;
  localparam logic [CLASS_W-1:0] CLS_SOFT = 3'd1;
  localparam logic [CLASS_W-1:0] CLS_PROG = 3'd2;
  localparam logic [CLASS_W-1:0] CLS_BRK  = 3'd3;
  localparam logic [CLASS_W-1:0] CLS_RST  = 3'd4;

  // External kind for level 15, never masked by the level test
  localparam logic [KIND_W-1:0] KIND_LVL15 = 6'd14;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLEAR = 2'd3
  } q_op_e;

  function automatic logic in_band(input logic [CLASS_W-1:0] c,
                                   input logic [CLASS_W-1:0] lo,
                                   input logic [CLASS_W-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction
endpackage

// File: rtl/irqq_gate.sv
module irqq_gate
  import irqq_pkg::*;
(
  input  logic [KIND_W-1:0]  kind,
  input  logic [CLASS_W-1:0] cls,
  input  logic               ext_enable,
  input  logic [LEVEL_W-1:0] cur_level,
  output logic               masked
);
  logic [LEVEL_W:0] level;
  logic             below;

  always_comb begin
    level  = {1'b0, kind[LEVEL_W-1:0]} + 1'b1;
    below  = (kind != KIND_LVL15) && (level < {1'b0, cur_level});
    masked = (cls == CLS_EXT) && (!ext_enable || below);
  end
endmodule

// File: rtl/irqq_locate.sv
module irqq_locate
  import irqq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic [KIND_W-1:0] kinds [DEPTH],
  input  logic [CNT_W-1:0]  count,
  input  logic [KIND_W-1:0] new_kind,
  output logic [CNT_W-1:0]  pos,
  output logic              hit
);
  always_comb begin
    pos = count;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < count) && (kinds[i] >= new_kind)) pos = CNT_W'(i);
    end
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) == pos) && (pos < count) && (kinds[i] == new_kind)) hit = 1'b1;
    end
  end
endmodule

// File: rtl/irqq_store.sv
module irqq_store
  import irqq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int SLOT_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  q_op_e              op,
  input  logic [CNT_W-1:0]   pos,
  input  logic [KIND_W-1:0]  new_kind,
  input  logic [CLASS_W-1:0] new_cls,
  input  logic [PC_W-1:0]    new_pc,
  input  logic [SLOT_W-1:0]  new_slot,
  input  logic [CLASS_W-1:0] clr_lo,
  input  logic [CLASS_W-1:0] clr_hi,
  output logic [KIND_W-1:0]  kinds   [DEPTH],
  output logic [CLASS_W-1:0] classes [DEPTH],
  output logic [PC_W-1:0]    pcs     [DEPTH],
  output logic [SLOT_W-1:0]  slots   [DEPTH],
  output logic [CNT_W-1:0]   count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KIND_W-1:0]  kind_q [DEPTH];
  logic [CLASS_W-1:0] cls_q  [DEPTH];
  logic [PC_W-1:0]    pc_q   [DEPTH];
  logic [SLOT_W-1:0]  slot_q [DEPTH];
  logic [CNT_W-1:0]   cnt_q;

  // Band-clear compaction network
  logic               keep [DEPTH];
  logic [CNT_W-1:0]   dest [DEPTH];
  logic [CNT_W-1:0]   kept_cnt;
  logic [KIND_W-1:0]  ck   [DEPTH];
  logic [CLASS_W-1:0] cc   [DEPTH];
  logic [PC_W-1:0]    cp   [DEPTH];
  logic [SLOT_W-1:0]  cs   [DEPTH];

  always_comb begin
    kept_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i]  = (CNT_W'(i) < cnt_q) && !in_band(cls_q[i], clr_lo, clr_hi);
      dest[i]  = kept_cnt;
      kept_cnt = kept_cnt + CNT_W'(keep[i]);
    end
    for (int j = 0; j < DEPTH; j++) begin
      ck[j] = kind_q[j];
      cc[j] = cls_q[j];
      cp[j] = pc_q[j];
      cs[j] = slot_q[j];
      for (int i = 0; i < DEPTH; i++) begin
        if (keep[i] && (dest[i] == CNT_W'(j))) begin
          ck[j] = kind_q[i];
          cc[j] = cls_q[i];
          cp[j] = pc_q[i];
          cs[j] = slot_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= '0;
        cls_q[i]  <= '0;
        pc_q[i]   <= '0;
        slot_q[i] <= '0;
      end
    end else begin
      case (op)
        OP_PUSH: begin
          for (int i = DEPTH - 1; i >= 1; i--) begin
            if (CNT_W'(i) > pos) begin
              kind_q[i] <= kind_q[i-1];
              cls_q[i]  <= cls_q[i-1];
              pc_q[i]   <= pc_q[i-1];
              slot_q[i] <= slot_q[i-1];
            end
          end
          kind_q[pos[IDX_W-1:0]] <= new_kind;
          cls_q[pos[IDX_W-1:0]]  <= new_cls;
          pc_q[pos[IDX_W-1:0]]   <= new_pc;
          slot_q[pos[IDX_W-1:0]] <= new_slot;
          cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: cnt_q <= cnt_q - 1'b1;
        OP_CLEAR: begin
          for (int i = 0; i < DEPTH; i++) begin
            kind_q[i] <= ck[i];
            cls_q[i]  <= cc[i];
            pc_q[i]   <= cp[i];
            slot_q[i] <= cs[i];
          end
          cnt_q <= kept_cnt;
        end
        default: ;
      endcase
    end
  end

  assign kinds   = kind_q;
  assign classes = cls_q;
  assign pcs     = pc_q;
  assign slots   = slot_q;
  assign count   = cnt_q;

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_sorted
    a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > CNT_W'(g + 1)) |-> (kind_q[g] <= kind_q[g+1]));
  end
endmodule

// File: rtl/irq_pend_queue.sv
module irq_pend_queue
  import irqq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int SLOT_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic [KIND_W-1:0]  ins_kind,
  input  logic [CLASS_W-1:0] ins_class,
  input  logic [PC_W-1:0]    ins_pc,
  input  logic [SLOT_W-1:0]  ins_slot,
  output logic               ins_dup,
  output logic               ins_masked,
  input  logic               ext_enable,
  input  logic [LEVEL_W-1:0] cur_level,
  output logic               tail_valid,
  input  logic               tail_ready,
  output logic [KIND_W-1:0]  tail_kind,
  output logic [CLASS_W-1:0] tail_class,
  output logic [PC_W-1:0]    tail_pc,
  output logic [SLOT_W-1:0]  tail_slot,
  input  logic               clr_req,
  input  logic [CLASS_W-1:0] clr_lo,
  input  logic [CLASS_W-1:0] clr_hi,
  output logic [CNT_W-1:0]   count,
  output logic               overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KIND_W-1:0]  kinds   [DEPTH];
  logic [CLASS_W-1:0] classes [DEPTH];
  logic [PC_W-1:0]    pcs     [DEPTH];
  logic [SLOT_W-1:0]  slots   [DEPTH];
  logic [CNT_W-1:0]   pos;
  logic               hit;
  logic               gated;
  logic               full;
  logic               pop_req;
  logic               ins_fire;
  logic [IDX_W-1:0]   tail_idx;
  logic               ovf_q;
  q_op_e              op;

  irqq_gate u_gate (
    .kind       (ins_kind),
    .cls        (ins_class),
    .ext_enable (ext_enable),
    .cur_level  (cur_level),
    .masked     (gated)
  );

  irqq_locate #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_locate (
    .kinds    (kinds),
    .count    (count),
    .new_kind (ins_kind),
    .pos      (pos),
    .hit      (hit)
  );

  always_comb begin
    full       = (count == CNT_W'(DEPTH));
    tail_valid = (count != '0);
    pop_req    = tail_valid && tail_ready;
    ins_ready  = !full && !clr_req && !pop_req;
    ins_fire   = ins_valid && ins_ready;
    ins_masked = ins_fire && gated;
    ins_dup    = ins_fire && !gated && hit && (ins_class == CLS_EXT);
    if (clr_req)                             op = OP_CLEAR;
    else if (pop_req)                        op = OP_POP;
    else if (ins_fire && !gated && !ins_dup) op = OP_PUSH;
    else                                     op = OP_NONE;
  end

  irqq_store #(.DEPTH(DEPTH), .PC_W(PC_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .pos      (pos),
    .new_kind (ins_kind),
    .new_cls  (ins_class),
    .new_pc   (ins_pc),
    .new_slot (ins_slot),
    .clr_lo   (clr_lo),
    .clr_hi   (clr_hi),
    .kinds    (kinds),
    .classes  (classes),
    .pcs      (pcs),
    .slots    (slots),
    .count    (count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                       ovf_q <= 1'b0;
    else if (ins_valid && full && !clr_req && !pop_req) ovf_q <= 1'b1;
  end
  assign overflow = ovf_q;

  always_comb begin
    tail_idx   = tail_valid ? IDX_W'(count - 1'b1) : '0;
    tail_kind  = kinds[tail_idx];
    tail_class = classes[tail_idx];
    tail_pc    = pcs[tail_idx];
    tail_slot  = slots[tail_idx];
  end

  a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_valid && tail_ready && !clr_req) |=> (count == $past(count) - 1'b1));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && count == CNT_W'(DEPTH) && !clr_req && !tail_ready) |=> overflow);
  a_r3_dup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_dup |=> $stable(count));
  a_r9_ready_block: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req || (tail_valid && tail_ready)) |-> !ins_ready);
  a_r6_clear_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count <= $past(count)));
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_masked |=> $stable(count));
endmodule

// File: tb/irq_pend_queue_bench.sv
module irq_pend_queue_bench;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [5:0]  ins_kind = '0;
  logic [2:0]  ins_class = '0;
  logic [31:0] ins_pc = '0;
  logic [1:0]  ins_slot = '0;
  logic        ins_dup, ins_masked;
  logic        ext_enable = 1'b1;
  logic [3:0]  cur_level = '0;
  logic        tail_valid;
  logic        tail_ready = 1'b0;
  logic [5:0]  tail_kind;
  logic [2:0]  tail_class;
  logic [31:0] tail_pc;
  logic [1:0]  tail_slot;
  logic        clr_req = 1'b0;
  logic [2:0]  clr_lo = '0, clr_hi = '0;
  logic [3:0]  count;
  logic        overflow;

  always #10 clk = ~clk;

  irq_pend_queue #(.DEPTH(D), .PC_W(32), .SLOT_W(2)) u_irq_pend_queue (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_kind(ins_kind),
    .ins_class(ins_class), .ins_pc(ins_pc), .ins_slot(ins_slot),
    .ins_dup(ins_dup), .ins_masked(ins_masked),
    .ext_enable(ext_enable), .cur_level(cur_level),
    .tail_valid(tail_valid), .tail_ready(tail_ready), .tail_kind(tail_kind),
    .tail_class(tail_class), .tail_pc(tail_pc), .tail_slot(tail_slot),
    .clr_req(clr_req), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .count(count), .overflow(overflow)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // Behavioural model
  logic [5:0]  mk [D];
  logic [2:0]  mc [D];
  logic [31:0] mp [D];
  logic [1:0]  ms [D];
  int          mcnt = 0;
  bit          movf = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int find_pos(input logic [5:0] k);
    for (int i = 0; i < mcnt; i++) if (mk[i] >= k) return i;
    return mcnt;
  endfunction

  function automatic bit gated(input logic [5:0] k, input logic [2:0] c);
    if (c != 3'd0) return 0;
    if (!ext_enable) return 1;
    return (k != 6'd14) && (int'(k) + 1 < int'(cur_level));
  endfunction

  task automatic m_insert(input logic [5:0] k, input logic [2:0] c,
                          input logic [31:0] pc, input logic [1:0] sl);
    int p;
    p = find_pos(k);
    for (int i = mcnt; i > p; i--) begin
      mk[i] = mk[i-1]; mc[i] = mc[i-1]; mp[i] = mp[i-1]; ms[i] = ms[i-1];
    end
    mk[p] = k; mc[p] = c; mp[p] = pc; ms[p] = sl;
    mcnt++;
  endtask

  task automatic m_clear(input logic [2:0] lo, input logic [2:0] hi);
    int n;
    n = 0;
    for (int i = 0; i < mcnt; i++) begin
      if (!(mc[i] >= lo && mc[i] <= hi)) begin
        mk[n] = mk[i]; mc[n] = mc[i]; mp[n] = mp[i]; ms[n] = ms[i];
        n++;
      end
    end
    mcnt = n;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " count"}, count, mcnt);
    chk({tag, " tail_valid"}, tail_valid, mcnt > 0);
    chk({tag, " overflow"}, overflow, movf);
    if (mcnt > 0) begin
      chk({tag, " tail_kind"}, tail_kind, mk[mcnt-1]);
      chk({tag, " tail_class"}, tail_class, mc[mcnt-1]);
      chk({tag, " tail_pc"}, tail_pc, mp[mcnt-1]);
      chk({tag, " tail_slot"}, tail_slot, ms[mcnt-1]);
    end
  endtask

  task automatic cyc(input bit iv, input logic [5:0] k, input logic [2:0] c,
                     input logic [31:0] pc, input logic [1:0] sl,
                     input bit pop, input bit clr, input logic [2:0] lo,
                     input logic [2:0] hi, input string tag);
    bit popeff, full, erdy, g, edup;
    int p;
    @(negedge clk);
    ins_valid = iv; ins_kind = k; ins_class = c; ins_pc = pc; ins_slot = sl;
    tail_ready = pop; clr_req = clr; clr_lo = lo; clr_hi = hi;
    #2;
    popeff = pop && (mcnt > 0);
    full   = (mcnt == D);
    erdy   = !full && !clr && !popeff;
    g      = gated(k, c);
    p      = find_pos(k);
    edup   = iv && erdy && !g && (c == 3'd0) && (p < mcnt) && (mk[p] == k);
    chk({tag, " ins_ready"}, ins_ready, erdy);
    chk({tag, " ins_masked"}, ins_masked, iv && erdy && g);
    chk({tag, " ins_dup"}, ins_dup, edup);
    @(posedge clk);
    #2;
    if (clr) m_clear(lo, hi);
    else if (popeff) mcnt--;
    else if (iv && erdy && !g && !edup) m_insert(k, c, pc, sl);
    if (iv && full && !clr && !popeff) movf = 1;
    ins_valid = 0; tail_ready = 0; clr_req = 0;
    check_state(tag);
  endtask

  task automatic ins(input logic [5:0] k, input logic [2:0] c, input logic [31:0] pc,
                     input logic [1:0] sl, input string tag);
    cyc(1, k, c, pc, sl, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 tail_valid", tail_valid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 ins_ready", ins_ready, 1);

    // R2 / R5 out-of-order inserts, equal program kinds
    ins(6'd20, 3'd2, 32'h100, 2'd1, "R2");
    ins(6'd3,  3'd0, 32'h104, 2'd0, "R2");
    ins(6'd62, 3'd3, 32'h108, 2'd2, "R2");
    ins(6'd15, 3'd1, 32'h10c, 2'd3, "R2");
    ins(6'd20, 3'd2, 32'h200, 2'd2, "R2");
    chk("R2 tail is break", tail_kind, 62);
    chk("R5 tail pc", tail_pc, 32'h108);
    chk("R5 tail slot", tail_slot, 2);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    chk("R7 count after pop", count, 4);
    chk("R2 older equal at tail", tail_pc, 32'h100);

    // R3 duplicate external
    ins(6'd3, 3'd0, 32'h300, 2'd0, "R3");
    chk("R3 count unchanged", count, 4);

    // R4 masking
    ext_enable = 0;
    ins(6'd14, 3'd0, 32'h400, 2'd0, "R4");
    ext_enable = 1; cur_level = 4'd10;
    ins(6'd5,  3'd0, 32'h404, 2'd0, "R4");
    ins(6'd9,  3'd0, 32'h408, 2'd1, "R4");
    cur_level = 4'd15;
    ins(6'd14, 3'd0, 32'h40c, 2'd1, "R4");
    ins(6'd13, 3'd0, 32'h410, 2'd1, "R4");
    chk("R4 count", count, 6);
    cur_level = 4'd0;

    // R6 band clears
    cyc(0, 0, 0, 0, 0, 0, 1, 3'd3, 3'd1, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 3'd0, 3'd1, "R6");
    chk("R6 count", count, 2);

    // R9 precedence
    cyc(1, 6'd40, 3'd2, 32'h500, 2'd0, 1, 0, 0, 0, "R9");
    cyc(1, 6'd40, 3'd2, 32'h504, 2'd0, 1, 1, 3'd4, 3'd4, "R9");

    // R8 fill and overflow
    for (int i = 0; i < D + 1; i++) ins(6'(16 + i), 3'd2, 32'(32'h600 + i), 2'(i), "R8");
    chk("R8 full ready", ins_ready, 0);
    chk("R8 overflow set", overflow, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'd0, 3'd4, "R6");

    // Random mix (R2)
    for (int n = 0; n < 3000; n++) begin
      int r, cl;
      logic [5:0] k;
      bit iv, pop, clr;
      r   = $urandom_range(99);
      iv  = r < 70;
      pop = $urandom_range(99) < 25;
      clr = $urandom_range(99) < 4;
      cl  = $urandom_range(4);
      case (cl)
        0: k = 6'($urandom_range(14));
        1: k = 6'd15;
        2: k = 6'($urandom_range(16, 40));
        3: k = 6'd62;
        default: k = 6'd63;
      endcase
      ext_enable = $urandom_range(9) != 0;
      cur_level  = 4'($urandom_range(15));
      cyc(iv, k, 3'(cl), $urandom, 2'($urandom_range(3)), pop, clr,
          3'($urandom_range(4)), 3'($urandom_range(4)), "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule